// File: doc/BRIEF.md
# Layer-wise neuron cluster allocator

This block places the neurons of a flattened neural network onto the processing elements (PEs) of a mesh. It walks the layers from first to last. Each layer is cut into groups of at most `pe_capacity` neurons, and every group gets its own PE. PE ids are handed out consecutively from 0. A new layer always begins on an unused PE, even when the last PE of the layer before is only partly filled. Each group travels as one record: its layer, its PE id and that id's (x, y) position in the mesh, its first neuron and its neuron count. The record also carries the destination set for the group's results, which is every PE allocated to the following layer. Because allocation is contiguous, that set is given as a base id and a count.

The network is described by `layer_neurons`, the capacity by `pe_capacity`, and the mesh by `mesh_w` and `mesh_h`. These inputs must stay stable while a run is in progress. A `start` pulse in the idle state begins a run. Records leave through a valid/ready handshake, at most one per cycle, and a one-cycle `done` pulse closes the run. If the mesh has too few nodes, the block raises `overflow` and stops early.

The controller has four states:
- IDLE: waits for `start`. It moves to SIZE, or straight to DONE when the capacity is 0.
- SIZE: counts how many PEs a layer needs by subtracting the capacity once per cycle. When the count is known it moves to DONE on overflow. After sizing the first layer it stays in SIZE to size the second. Otherwise it moves to EMIT.
- EMIT: offers the records of the current layer. When the layer is finished it moves to SIZE to size the layer after next, or to DONE after the last layer.
- DONE: lasts one cycle and returns to IDLE.

Top module: `layer_cluster_alloc`

## Requirements
- R1: After reset, `rec_valid`, `done` and `overflow` are 0.
- R2: Records come out in layer order, and each record holds neurons of one layer only. Group g of layer l has `rec_first` = g*capacity and `rec_count` = min(capacity, n_l - g*capacity), where n_l is the neuron count of layer l. A record's count is never 0 and never exceeds the capacity.
- R3: PE ids start at 0 and rise by 1 with every record. Layer l+1 starts on the id that follows the last id of layer l. A layer with 0 neurons produces no record and uses no PE.
- R4: `rec_x` = id mod `mesh_w` and `rec_y` = id div `mesh_w`.
- R5: `rec_dst_base` is the first PE id of layer l+1 and `rec_dst_cnt` is the number of PEs that layer uses, ceil(n_{l+1}/capacity). For the last layer `rec_dst_cnt` is 0 and `rec_dst_base` is the id after the last id used.
- R6: While `rec_valid` is 1 and `rec_ready` is 0, `rec_valid` stays 1 and every record field holds its value. A record is consumed only in a cycle where both are 1.
- R7: Let k be the first layer where the PEs used by layers 0..k together exceed `mesh_w*mesh_h`. Then `overflow` rises, records are issued only for layers before k-1, and the run ends. A capacity of 0 gives overflow with no records. `overflow` holds until the next start.
- R8: `done` is a single-cycle pulse. It comes after the last record is consumed (or after overflow), and `rec_valid` is 0 while it is high.
- R9: `start` has no effect unless the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when idle |
| layer_neurons | input | LAYERS*NW | Neuron count of each layer, layer 0 in the lowest slice |
| pe_capacity | input | NW | Maximum neurons per PE |
| mesh_w | input | DIMW | Mesh width in nodes |
| mesh_h | input | DIMW | Mesh height in nodes |
| rec_valid | output | 1 | A group record is offered |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_layer | output | LW | Layer index of the group |
| rec_pe | output | 2*DIMW | Linear PE id, row-major |
| rec_x | output | DIMW | PE column |
| rec_y | output | DIMW | PE row |
| rec_first | output | NW | Index of the group's first neuron within its layer |
| rec_count | output | NW | Neurons in the group |
| rec_dst_base | output | 2*DIMW | First destination PE id |
| rec_dst_cnt | output | 2*DIMW | Number of destination PEs |
| done | output | 1 | Run finished (one cycle) |
| overflow | output | 1 | Mesh too small; sticky until next start |

## Verification
Sizing takes a variable number of cycles, about n_l/capacity per layer, so the bench never waits a fixed delay for a record. It sets `rec_ready` at the falling edge and then samples `rec_valid` and the fields in the same half cycle. A record counts as consumed exactly when both are high at that falling edge, and that record is compared with the next entry of an arithmetically built list. A stall seen at one falling edge is checked at the next one for unchanged fields. The checks on `done`, the record total and `overflow` are made at the falling edge where `done` is seen, and the pulse is required to be gone one cycle later.

// File: rtl/cl_alloc_pkg.sv
package cl_alloc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SIZE = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } alloc_state_e;
endpackage

// File: rtl/cl_group_slice.sv
module cl_group_slice #(
    parameter int NW = 12
) (
    input  logic [NW-1:0] rem,
    input  logic [NW-1:0] cap,
    output logic [NW-1:0] take,
    output logic [NW-1:0] left
);
    always_comb begin
        take = (rem < cap) ? rem : cap;
        left = rem - take;
    end
endmodule

// File: rtl/cl_pe_cursor.sv
module cl_pe_cursor #(
    parameter int DIMW = 4,
    localparam int PW = 2 * DIMW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [DIMW-1:0] mesh_w,
    output logic [PW-1:0]   pe,
    output logic [DIMW-1:0] x,
    output logic [DIMW-1:0] y
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe <= '0;
            x  <= '0;
            y  <= '0;
        end else if (clear) begin
            pe <= '0;
            x  <= '0;
            y  <= '0;
        end else if (step) begin
            pe <= pe + 1'b1;
            if ({1'b0, x} + 1'b1 >= {1'b0, mesh_w}) begin
                x <= '0;
                y <= y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end

    // R4
    coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (x < mesh_w));
endmodule

// File: rtl/layer_cluster_alloc.sv
module layer_cluster_alloc
    import cl_alloc_pkg::*;
#(
    parameter int LAYERS = 4,
    parameter int NW     = 12,
    parameter int DIMW   = 4,
    localparam int LW = (LAYERS > 1) ? $clog2(LAYERS) : 1,
    localparam int PW = 2 * DIMW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [LAYERS-1:0][NW-1:0]  layer_neurons,
    input  logic [NW-1:0]              pe_capacity,
    input  logic [DIMW-1:0]            mesh_w,
    input  logic [DIMW-1:0]            mesh_h,
    output logic                       rec_valid,
    input  logic                       rec_ready,
    output logic [LW-1:0]              rec_layer,
    output logic [PW-1:0]              rec_pe,
    output logic [DIMW-1:0]            rec_x,
    output logic [DIMW-1:0]            rec_y,
    output logic [NW-1:0]              rec_first,
    output logic [NW-1:0]              rec_count,
    output logic [PW-1:0]              rec_dst_base,
    output logic [PW-1:0]              rec_dst_cnt,
    output logic                       done,
    output logic                       overflow
);
    localparam int EW = ((NW > PW) ? NW : PW) + 1;

    alloc_state_e state, state_nx;

    logic [LW-1:0] lay;
    logic [NW-1:0] sz_rem, sz_pcs, sz_take, sz_left;
    logic          sz_first;
    logic [PW-1:0] nxt_base, nxt_cnt;
    logic [NW-1:0] em_rem, em_first, em_take, em_left;
    logic          ovf;

    logic [EW-1:0] nodes_e, sz_end;
    logic          sz_done, sz_fit, handshake, layer_end, last_layer, run_go;

    function automatic logic [NW-1:0] neurons_at(input int idx);
        logic [NW-1:0] r;
        r = '0;
        for (int i = 0; i < LAYERS; i++)
            if (i == idx) r = layer_neurons[i];
        return r;
    endfunction

    cl_group_slice #(.NW(NW)) i_size_slice (
        .rem(sz_rem), .cap(pe_capacity), .take(sz_take), .left(sz_left)
    );

    cl_group_slice #(.NW(NW)) i_emit_slice (
        .rem(em_rem), .cap(pe_capacity), .take(em_take), .left(em_left)
    );

    cl_pe_cursor #(.DIMW(DIMW)) i_cursor (
        .clk(clk), .rst_n(rst_n), .clear(run_go), .step(handshake),
        .mesh_w(mesh_w), .pe(rec_pe), .x(rec_x), .y(rec_y)
    );

    always_comb begin
        run_go     = (state == ST_IDLE) && start;
        nodes_e    = EW'(mesh_w) * EW'(mesh_h);
        sz_end     = (sz_first ? '0 : EW'(nxt_base)) + EW'(sz_pcs);
        sz_done    = (sz_rem == '0);
        sz_fit     = (sz_end <= nodes_e);
        handshake  = rec_valid && rec_ready;
        layer_end  = (state == ST_EMIT) &&
                     ((em_rem == '0) || (handshake && (em_left == '0)));
        last_layer = (int'(lay) == LAYERS - 1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (pe_capacity == '0) ? ST_DONE : ST_SIZE;
            ST_SIZE: if (sz_done) begin
                if (!sz_fit)       state_nx = ST_DONE;
                else if (sz_first) state_nx = ST_SIZE;
                else               state_nx = ST_EMIT;
            end
            ST_EMIT: if (layer_end) state_nx = last_layer ? ST_DONE : ST_SIZE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lay      <= '0;
            sz_rem   <= '0;
            sz_pcs   <= '0;
            sz_first <= 1'b0;
            nxt_base <= '0;
            nxt_cnt  <= '0;
            em_rem   <= '0;
            em_first <= '0;
            ovf      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ovf      <= (pe_capacity == '0);
                    lay      <= '0;
                    sz_rem   <= neurons_at(0);
                    sz_pcs   <= '0;
                    sz_first <= 1'b1;
                    nxt_base <= '0;
                end
                ST_SIZE: begin
                    if (!sz_done) begin
                        sz_rem <= sz_left;
                        sz_pcs <= sz_pcs + 1'b1;
                    end else if (!sz_fit) begin
                        ovf <= 1'b1;
                    end else if (sz_first) begin
                        nxt_base <= PW'(sz_pcs);
                        sz_first <= 1'b0;
                        sz_rem   <= neurons_at(1);
                        sz_pcs   <= '0;
                    end else begin
                        nxt_cnt  <= PW'(sz_pcs);
                        em_rem   <= neurons_at(int'(lay));
                        em_first <= '0;
                    end
                end
                ST_EMIT: begin
                    if (handshake) begin
                        em_rem   <= em_left;
                        em_first <= em_first + em_take;
                    end
                    if (layer_end && !last_layer) begin
                        lay      <= lay + 1'b1;
                        nxt_base <= nxt_base + nxt_cnt;
                        sz_rem   <= neurons_at(int'(lay) + 2);
                        sz_pcs   <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rec_valid    = (state == ST_EMIT) && (em_rem != '0);
        rec_layer    = lay;
        rec_first    = em_first;
        rec_count    = em_take;
        rec_dst_base = nxt_base;
        rec_dst_cnt  = nxt_cnt;
        done         = (state == ST_DONE);
        overflow     = ovf;
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_count != '0) && (rec_count <= pe_capacity));

    // R6
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> rec_valid && $stable(rec_pe) &&
        $stable(rec_first) && $stable(rec_count) && $stable(rec_layer) &&
        $stable(rec_dst_base) && $stable(rec_dst_cnt));

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rec_valid);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !rec_valid);
endmodule

// File: tb/test_layer_cluster_alloc.sv
`timescale 1ns/1ps
module test_layer_cluster_alloc;
    localparam int L = 4, NW = 12, DIMW = 4, PW = 8, LW = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start, rec_valid, rec_ready, done, overflow;
    logic [L-1:0][NW-1:0] layer_neurons;
    logic [NW-1:0] pe_capacity, rec_first, rec_count;
    logic [DIMW-1:0] mesh_w, mesh_h, rec_x, rec_y;
    logic [LW-1:0] rec_layer;
    logic [PW-1:0] rec_pe, rec_dst_base, rec_dst_cnt;

    layer_cluster_alloc #(.LAYERS(L), .NW(NW), .DIMW(DIMW)) i_layer_cluster_alloc (
        .clk(clk), .rst_n(rst_n), .start(start), .layer_neurons(layer_neurons),
        .pe_capacity(pe_capacity), .mesh_w(mesh_w), .mesh_h(mesh_h),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_layer(rec_layer),
        .rec_pe(rec_pe), .rec_x(rec_x), .rec_y(rec_y), .rec_first(rec_first),
        .rec_count(rec_count), .rec_dst_base(rec_dst_base), .rec_dst_cnt(rec_dst_cnt),
        .done(done), .overflow(overflow)
    );

    int n_chk = 0, n_bad = 0;
    int e_layer[300], e_pe[300], e_first[300], e_cnt[300], e_db[300], e_dc[300];
    int e_num;
    bit e_ovf;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic build_exp(input int n[4], input int cap, input int nodes);
        int pcs[4], base[5], k, lim;
        e_num = 0;
        e_ovf = 0;
        if (cap == 0) begin
            e_ovf = 1;
            return;
        end
        base[0] = 0;
        for (int l = 0; l < 4; l++) begin
            pcs[l] = (n[l] + cap - 1) / cap;
            base[l+1] = base[l] + pcs[l];
        end
        k = 4;
        for (int l = 3; l >= 0; l--) if (base[l+1] > nodes) k = l;
        e_ovf = (k < 4);
        lim = e_ovf ? k - 1 : 4;
        for (int l = 0; l < lim; l++) begin
            for (int g = 0; g < pcs[l]; g++) begin
                e_layer[e_num] = l;
                e_pe[e_num]    = base[l] + g;
                e_first[e_num] = g * cap;
                e_cnt[e_num]   = (n[l] - g * cap < cap) ? n[l] - g * cap : cap;
                e_db[e_num]    = base[l+1];
                e_dc[e_num]    = (l < 3) ? pcs[l+1] : 0;
                e_num++;
            end
        end
    endtask

    task automatic run_case(input int n0, input int n1, input int n2, input int n3,
                            input int cap, input int w, input int h,
                            input int mode, input bit poke);
        int n[4], idx, cyc, s_pe, s_first, s_cnt, s_layer;
        bit finished, stalled;
        n = '{n0, n1, n2, n3};
        build_exp(n, cap, w * h);
        @(negedge clk);
        for (int l = 0; l < 4; l++) layer_neurons[l] = NW'(n[l]);
        pe_capacity = NW'(cap);
        mesh_w = DIMW'(w);
        mesh_h = DIMW'(h);
        start = 1'b1;
        idx = 0; cyc = 0; finished = 0; stalled = 0;
        s_pe = 0; s_first = 0; s_cnt = 0; s_layer = 0;
        while (!finished) begin
            @(negedge clk);
            cyc++;
            start = (poke && (cyc == 4 || cyc == 9)) ? 1'b1 : 1'b0;
            rec_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (stalled) begin
                chk("R6 valid held", int'(rec_valid), 1);
                chk("R6 pe held", int'(rec_pe), s_pe);
                chk("R6 first held", int'(rec_first), s_first);
                chk("R6 count held", int'(rec_count), s_cnt);
                chk("R6 layer held", int'(rec_layer), s_layer);
            end
            stalled = rec_valid && !rec_ready;
            s_pe = int'(rec_pe); s_first = int'(rec_first);
            s_cnt = int'(rec_count); s_layer = int'(rec_layer);
            if (rec_valid && rec_ready) begin
                if (idx < e_num) begin
                    chk("R2 layer", int'(rec_layer), e_layer[idx]);
                    chk("R2 first", int'(rec_first), e_first[idx]);
                    chk("R2 count", int'(rec_count), e_cnt[idx]);
                    chk("R3 pe", int'(rec_pe), e_pe[idx]);
                    chk("R4 x", int'(rec_x), e_pe[idx] % w);
                    chk("R4 y", int'(rec_y), e_pe[idx] / w);
                    chk("R5 dst base", int'(rec_dst_base), e_db[idx]);
                    chk("R5 dst cnt", int'(rec_dst_cnt), e_dc[idx]);
                end else begin
                    chk("R7 extra record", idx, e_num);
                end
                idx++;
            end
            if (done) begin
                chk("R8 valid low at done", int'(rec_valid), 0);
                chk("R7 overflow", int'(overflow), int'(e_ovf));
                if (poke) chk("R9 record total", idx, e_num);
                else      chk("R2 record total", idx, e_num);
                finished = 1;
            end
            if (cyc > 3000) begin
                chk("watchdog run", cyc, 0);
                finished = 1;
            end
        end
        @(negedge clk);
        chk("R8 done single cycle", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pat[8][4];
        int msz[5][2];
        int run;
        rst_n = 1'b0; start = 1'b0; rec_ready = 1'b0;
        layer_neurons = '0; pe_capacity = '0; mesh_w = '0; mesh_h = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", int'(rec_valid), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 overflow after reset", int'(overflow), 0);
        rst_n = 1'b1;

        // large capacity on a 12x12 mesh
        run_case(4000, 3456, 100, 0, 3456, 12, 12, 0, 0);
        // R7: zero capacity
        run_case(3, 3, 3, 3, 0, 4, 4, 0, 0);
        // R9: start pokes during a run
        run_case(9, 7, 5, 3, 2, 6, 6, 1, 1);
        // R7: exact fit on layers 0..1, layer 2 spills
        run_case(4, 4, 4, 4, 2, 2, 2, 1, 0);

        pat = '{'{3,5,2,4}, '{1,1,1,1}, '{7,0,6,2}, '{0,0,0,0},
                '{4,4,4,4}, '{10,3,0,9}, '{2,9,1,0}, '{12,1,5,3}};
        msz = '{'{2,2}, '{3,3}, '{4,3}, '{6,6}, '{1,5}};
        run = 0;
        for (int p = 0; p < 8; p++)
            for (int c = 1; c <= 5; c++)
                for (int m = 0; m < 5; m++) begin
                    run_case(pat[p][0], pat[p][1], pat[p][2], pat[p][3],
                             c, msz[m][0], msz[m][1], run % 2, 0);
                    run++;
                end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule